// File: doc/BRIEF.md
# TCP Handshake Screening Gate

This block stands in front of a protected server and decides what happens to each inbound TCP segment before any of it reaches the server. It takes one parsed header descriptor per transfer. Each descriptor carries the protocol kind, the direction, the source address and port, the destination port, the SYN/ACK/RST flags, and the sequence and acknowledgement numbers. For each descriptor the block returns exactly one action: forward it, answer with a SYN-ACK, answer with a reset, or discard it. It also returns the numbers an external packet builder needs to form the reply.

A client that is not yet trusted never reaches the server. Its SYN is answered by the gate with a SYN-ACK whose sequence number is a keyed hash of the client's address, ports and a secret. Nothing is stored for the half-open exchange. When the client completes the handshake with an acknowledgement equal to that hash plus one, the gate records its address in a direct-mapped whitelist and resets the probe connection. The client's next SYN, and everything after it, is forwarded. Whitelist entries lapse after a programmable number of ticks. A newer source that maps to the same slot evicts an older one.

Top module: `syn_screen_gate`

## Requirements
- R1: Descriptors that are not TCP (`in_tcp`=0), that travel outbound (`in_outbound`=1), or whose destination port lies outside `prot_lo`..`prot_hi` inclusive are forwarded, whatever their flags.
- R2: A SYN-only segment (flags bit0 SYN=1, bit1 ACK=0, bit2 RST=0) from a source that is not whitelisted yields action reply-SYNACK, `out_seq` = cookie and `out_ack` = `in_seq`+1. The cookie is a deterministic function of source IP, source port, destination port and `secret`.
- R3: An ACK-only segment from a non-whitelisted source with `in_ack` equal to cookie+1 adds the source IP to the whitelist and yields action reply-RST, with `out_seq` = `in_ack` and `out_ack` = 0.
- R4: Any other segment to a protected port from a non-whitelisted source is dropped and leaves the whitelist unchanged. This includes an ACK carrying a wrong cookie.
- R5: Any segment from a whitelisted source is forwarded, with `out_seq` and `out_ack` equal to the input values.
- R6: Changing `secret` changes the cookie, so an acknowledgement built on the old cookie is dropped.
- R7: The whitelist slot is the XOR of the four bytes of the source IP (256 slots). Whitelisting a second address with the same slot evicts the first.
- R8: A whitelist entry stays valid while fewer than `wl_timeout` ticks (`tick` high cycles) have passed since it was written, and lapses once `wl_timeout` ticks have passed.
- R9: `out_action` is one-hot when `out_valid` is high: bit0 forward, bit1 reply-SYNACK, bit2 reply-RST, bit3 drop. `out_ip`, `out_sport` and `out_dport` echo the descriptor.
- R10: A descriptor accepted on a rising edge with `out_ready` high appears on `out_valid` exactly three rising edges later. While `out_valid` is high and `out_ready` is low, all outputs hold and `in_ready` is low.
- R11: After reset `out_valid` is low, `in_ready` is high, and the whitelist is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_tcp | input | 1 | Descriptor is TCP |
| in_outbound | input | 1 | Segment travels from server side to client side |
| in_ip | input | 32 | Source IP |
| in_sport | input | 16 | Source port |
| in_dport | input | 16 | Destination port |
| in_flags | input | 3 | bit0 SYN, bit1 ACK, bit2 RST |
| in_seq | input | 32 | Sequence number |
| in_ack | input | 32 | Acknowledgement number |
| secret | input | 32 | Cookie key |
| prot_lo | input | 16 | Lowest protected port |
| prot_hi | input | 16 | Highest protected port |
| wl_timeout | input | 16 | Whitelist lifetime in ticks |
| tick | input | 1 | Advances the whitelist time base |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Decision taken when high with out_valid |
| out_action | output | 4 | One-hot action |
| out_seq | output | 32 | Reply sequence number, or input value on forward/drop |
| out_ack | output | 32 | Reply acknowledgement number, or input value on forward/drop |
| out_ip | output | 32 | Echoed source IP |
| out_sport | output | 16 | Echoed source port |
| out_dport | output | 16 | Echoed destination port |

## Verification
Every decision is due three rising edges after the edge that accepts its descriptor. The bench drives each descriptor on a falling edge and checks that `out_valid` is still low at the falling edge after the second of those three edges. It then samples the decision at the falling edge after the third. Whitelist effects are observed only through the next descriptor's decision, which the bench sends after the previous one has fully left. Ageing is exercised by counting tick pulses between those transfers. A stalled output is sampled at several falling edges while `out_ready` is low.

// File: rtl/syn_screen_gate.sv
module syn_screen_gate #(
  parameter int IDXW = 8,
  parameter int TW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_tcp,
  input  logic          in_outbound,
  input  logic [31:0]   in_ip,
  input  logic [15:0]   in_sport,
  input  logic [15:0]   in_dport,
  input  logic [2:0]    in_flags,
  input  logic [31:0]   in_seq,
  input  logic [31:0]   in_ack,
  input  logic [31:0]   secret,
  input  logic [15:0]   prot_lo,
  input  logic [15:0]   prot_hi,
  input  logic [TW-1:0] wl_timeout,
  input  logic          tick,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    out_action,
  output logic [31:0]   out_seq,
  output logic [31:0]   out_ack,
  output logic [31:0]   out_ip,
  output logic [15:0]   out_sport,
  output logic [15:0]   out_dport
);
  localparam int DEPTH = 1 << IDXW;
  localparam logic [3:0] A_FWD = 4'b0001, A_SYNACK = 4'b0010, A_RST = 4'b0100, A_DROP = 4'b1000;

  typedef struct packed {
    logic        tcp;
    logic        ob;
    logic [31:0] ip;
    logic [15:0] sp;
    logic [15:0] dp;
    logic [2:0]  fl;
    logic [31:0] sq;
    logic [31:0] ak;
  } desc_t;

  desc_t p1, p2, p3;
  logic v1, v2, v3;
  logic [31:0] h2, ck3;
  logic [IDXW-1:0] idx3;
  logic [TW-1:0] now;

  logic [DEPTH-1:0] wl_v;
  logic [31:0]      wl_tag [DEPTH];
  logic [TW-1:0]    wl_ts  [DEPTH];

  wire adv = !out_valid || out_ready;
  assign in_ready = adv;

  desc_t din;
  assign din = '{tcp: in_tcp, ob: in_outbound, ip: in_ip, sp: in_sport, dp: in_dport,
                 fl: in_flags, sq: in_seq, ak: in_ack};

  wire [7:0] ipx = p2.ip[31:24] ^ p2.ip[23:16] ^ p2.ip[15:8] ^ p2.ip[7:0];
  wire [31:0] h1   = (p1.ip ^ secret) * 32'h9E37_79B1;
  wire [31:0] mixa = h2 ^ {p2.sp, p2.dp} ^ (h2 >> 15);
  wire [31:0] mixb = mixa * 32'h85EB_CA6B;
  wire [31:0] ck2  = mixb ^ (mixb >> 13);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid; v2 <= v1; v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      p1   <= din;
      p2   <= p1;
      h2   <= h1;
      p3   <= p2;
      ck3  <= ck2;
      idx3 <= IDXW'(ipx);
    end
  end

  wire [TW-1:0] age  = now - wl_ts[idx3];
  wire          hit  = wl_v[idx3] && (wl_tag[idx3] == p3.ip) && (age < wl_timeout);
  wire          prot = (p3.dp >= prot_lo) && (p3.dp <= prot_hi);
  wire          byp  = !p3.tcp || p3.ob || !prot;
  wire          syn_only = p3.fl == 3'b001;
  wire          ack_only = p3.fl == 3'b010;
  wire          good = ack_only && (p3.ak == ck3 + 32'd1);

  logic [3:0]  d_act;
  logic [31:0] d_seq, d_ack;
  always_comb begin
    d_act = A_DROP;
    d_seq = p3.sq;
    d_ack = p3.ak;
    if (byp || hit) begin
      d_act = A_FWD;
    end else if (syn_only) begin
      d_act = A_SYNACK;
      d_seq = ck3;
      d_ack = p3.sq + 32'd1;
    end else if (good) begin
      d_act = A_RST;
      d_seq = p3.ak;
      d_ack = 32'd0;
    end
  end

  wire ins = adv && v3 && (d_act == A_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now  <= '0;
      wl_v <= '0;
    end else begin
      if (tick) now <= now + 1'b1;
      if (ins) wl_v[idx3] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins) begin
      wl_tag[idx3] <= p3.ip;
      wl_ts[idx3]  <= now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= v3;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_action <= d_act;
      out_seq    <= d_seq;
      out_ack    <= d_ack;
      out_ip     <= p3.ip;
      out_sport  <= p3.sp;
      out_dport  <= p3.dp;
    end
  end

  a_r9_onehot_action: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_action) == 1);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_action) && $stable(out_seq) && $stable(out_ack)));

  a_r10_no_accept_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
    ins |=> wl_v[$past(idx3)]);

  a_r10_valid_from_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(v3));

  a_r5_fwd_keeps_numbers: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v3 && hit) |=> (out_action == A_FWD && out_seq == $past(p3.sq)));
endmodule

// File: tb/sim_syn_screen_gate.sv
module sim_syn_screen_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic in_tcp = 1'b1, in_outbound = 1'b0;
  logic [31:0] in_ip = '0, in_seq = '0, in_ack = '0, secret = 32'h1234_5678;
  logic [15:0] in_sport = '0, in_dport = '0, prot_lo = 16'd80, prot_hi = 16'd443;
  logic [2:0]  in_flags = '0;
  logic [15:0] wl_timeout = 16'd1000;
  logic tick = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [3:0] out_action;
  logic [31:0] out_seq, out_ack, out_ip;
  logic [15:0] out_sport, out_dport;

  localparam logic [3:0] FWD = 4'b0001, SYNACK = 4'b0010, RST = 4'b0100, DROP = 4'b1000;
  localparam logic [2:0] F_SYN = 3'b001, F_ACK = 3'b010, F_SYNACK = 3'b011, F_RST = 3'b100;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] r_act;
  logic [31:0] r_seq, r_ack, r_ip;

  syn_screen_gate u0 (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic tcp, input logic ob, input logic [31:0] ip, input logic [15:0] sp,
                      input logic [15:0] dp, input logic [2:0] fl, input logic [31:0] sq, input logic [31:0] ak);
    @(negedge clk);
    in_tcp = tcp; in_outbound = ob; in_ip = ip; in_sport = sp; in_dport = dp;
    in_flags = fl; in_seq = sq; in_ack = ak; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R10 early", {31'd0, out_valid}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid, "R10 latency", {31'd0, out_valid}, 32'd1);
    r_act = out_action; r_seq = out_seq; r_ack = out_ack; r_ip = out_ip;
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  logic [31:0] ck [8];
  logic [31:0] c_old, c_a, c_b;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R11 out_valid", {31'd0, out_valid}, 32'd0);
    check(in_ready, "R11 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    xfer(1'b0, 1'b0, 32'h0101_0101, 16'd5, 16'd80, F_SYN, 32'd10, 32'd0);
    check(r_act == FWD, "R1 non-tcp", {28'd0, r_act}, {28'd0, FWD});
    xfer(1'b1, 1'b1, 32'h0101_0101, 16'd80, 16'd5, F_SYNACK, 32'd10, 32'd0);
    check(r_act == FWD, "R1 outbound", {28'd0, r_act}, {28'd0, FWD});
    xfer(1'b1, 1'b0, 32'h0101_0101, 16'd5, 16'd79, F_SYN, 32'd10, 32'd0);
    check(r_act == FWD, "R1 port below", {28'd0, r_act}, {28'd0, FWD});
    xfer(1'b1, 1'b0, 32'h0101_0101, 16'd5, 16'd444, F_ACK, 32'd10, 32'd0);
    check(r_act == FWD, "R1 port above", {28'd0, r_act}, {28'd0, FWD});

    for (int i = 0; i < 8; i++) begin
      automatic logic [31:0] ip = 32'hC0A8_0000 + i * 37 + 1;
      automatic logic [15:0] sp = 16'(1000 + i);
      automatic logic [15:0] dp = (i % 2) ? 16'd443 : 16'd80;
      automatic logic [31:0] s = 32'h5000_0000 + i;
      xfer(1'b1, 1'b0, ip, sp, dp, F_SYN, s, 32'd0);
      check(r_act == SYNACK, "R2 action", {28'd0, r_act}, {28'd0, SYNACK});
      check(r_ack == s + 1, "R2 ack", r_ack, s + 1);
      check(r_ip == ip, "R9 echo ip", r_ip, ip);
      ck[i] = r_seq;
      xfer(1'b1, 1'b0, ip, sp, dp, F_SYN, s + 7, 32'd0);
      check(r_seq == ck[i], "R2 deterministic", r_seq, ck[i]);
      xfer(1'b1, 1'b0, ip, sp, dp, F_ACK, s + 1, ck[i] + 2);
      check(r_act == DROP, "R4 bad cookie", {28'd0, r_act}, {28'd0, DROP});
      xfer(1'b1, 1'b0, ip, sp, dp, F_SYNACK, s + 1, ck[i] + 1);
      check(r_act == DROP, "R4 synack flags", {28'd0, r_act}, {28'd0, DROP});
      xfer(1'b1, 1'b0, ip, sp, dp, F_SYN, s, 32'd0);
      check(r_act == SYNACK, "R4 not listed", {28'd0, r_act}, {28'd0, SYNACK});
      xfer(1'b1, 1'b0, ip, sp, dp, F_ACK, s + 1, ck[i] + 1);
      check(r_act == RST, "R3 action", {28'd0, r_act}, {28'd0, RST});
      check(r_seq == ck[i] + 1, "R3 seq", r_seq, ck[i] + 1);
      check(r_ack == 32'd0, "R3 ack", r_ack, 32'd0);
      xfer(1'b1, 1'b0, ip, sp, dp, F_SYN, s + 100, 32'h0000_0042);
      check(r_act == FWD, "R5 listed syn", {28'd0, r_act}, {28'd0, FWD});
      check(r_seq == s + 100, "R5 seq", r_seq, s + 100);
      check(r_ack == 32'h42, "R5 ack", r_ack, 32'h42);
      xfer(1'b1, 1'b0, ip, sp, dp, F_RST, s, 32'd0);
      check(r_act == FWD, "R5 listed rst", {28'd0, r_act}, {28'd0, FWD});
    end

    xfer(1'b1, 1'b0, 32'h0707_0707, 16'd7, 16'd80, F_SYN, 32'd1, 32'd0);
    c_old = r_seq;
    @(negedge clk); secret = 32'hCAFE_F00D;
    xfer(1'b1, 1'b0, 32'h0707_0707, 16'd7, 16'd80, F_SYN, 32'd1, 32'd0);
    check(r_seq != c_old, "R6 cookie changes", r_seq, c_old);
    xfer(1'b1, 1'b0, 32'h0707_0707, 16'd7, 16'd80, F_ACK, 32'd2, c_old + 1);
    check(r_act == DROP, "R6 old cookie", {28'd0, r_act}, {28'd0, DROP});

    xfer(1'b1, 1'b0, 32'h0A00_0001, 16'd9, 16'd80, F_SYN, 32'd1, 32'd0);
    c_a = r_seq;
    xfer(1'b1, 1'b0, 32'h0A00_0001, 16'd9, 16'd80, F_ACK, 32'd2, c_a + 1);
    check(r_act == RST, "R7 first listed", {28'd0, r_act}, {28'd0, RST});
    xfer(1'b1, 1'b0, 32'h0B00_0000, 16'd9, 16'd80, F_SYN, 32'd1, 32'd0);
    c_b = r_seq;
    xfer(1'b1, 1'b0, 32'h0B00_0000, 16'd9, 16'd80, F_ACK, 32'd2, c_b + 1);
    check(r_act == RST, "R7 second listed", {28'd0, r_act}, {28'd0, RST});
    xfer(1'b1, 1'b0, 32'h0A00_0001, 16'd9, 16'd80, F_SYN, 32'd1, 32'd0);
    check(r_act == SYNACK, "R7 evicted", {28'd0, r_act}, {28'd0, SYNACK});
    xfer(1'b1, 1'b0, 32'h0B00_0000, 16'd9, 16'd80, F_SYN, 32'd1, 32'd0);
    check(r_act == FWD, "R7 survivor", {28'd0, r_act}, {28'd0, FWD});

    @(negedge clk); wl_timeout = 16'd3;
    xfer(1'b1, 1'b0, 32'h0C0C_0C0C, 16'd3, 16'd80, F_SYN, 32'd1, 32'd0);
    c_a = r_seq;
    xfer(1'b1, 1'b0, 32'h0C0C_0C0C, 16'd3, 16'd80, F_ACK, 32'd2, c_a + 1);
    check(r_act == RST, "R8 listed", {28'd0, r_act}, {28'd0, RST});
    pulse_ticks(2);
    xfer(1'b1, 1'b0, 32'h0C0C_0C0C, 16'd3, 16'd80, F_SYN, 32'd1, 32'd0);
    check(r_act == FWD, "R8 before lapse", {28'd0, r_act}, {28'd0, FWD});
    pulse_ticks(1);
    xfer(1'b1, 1'b0, 32'h0C0C_0C0C, 16'd3, 16'd80, F_SYN, 32'd1, 32'd0);
    check(r_act == SYNACK, "R8 lapsed", {28'd0, r_act}, {28'd0, SYNACK});
    @(negedge clk); wl_timeout = 16'd1000;

    @(negedge clk); out_ready = 1'b0;
    xfer(1'b1, 1'b0, 32'h0D0D_0D0E, 16'd4, 16'd80, F_SYN, 32'd9, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid && out_action == r_act && out_seq == r_seq && out_ack == r_ack,
            "R10 hold", out_seq, r_seq);
      check(!in_ready, "R10 in_ready low", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R10 release", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule